// File: doc/BRIEF.md
# Counter Event Indicator Aggregation Tree

This block gathers three event conditions from each of a parameterised number of performance counters: a wrap (overflow or underflow), a command trigger and a threshold crossing. It merges them into two independent outputs. Each counter selects which of its event classes count as "hits". The hits then feed two paths. The first is a shared indicator signal, registered once, which can take over the output-enable and data of a general-purpose pin so that external observers see events without servicing an interrupt. The second is a sticky interrupt status bit that drives an interrupt request line and is cleared by writing a one to it.

Software configures the block through a small synchronous register port. Each counter owns a 16-byte window holding a command word, which carries its enables, and a read-only event word, which mirrors its live event inputs. A global word holds the two master enables. A status word holds the interrupt bit. When the global indicator enable is clear, the pin follows the general-purpose I/O settings unchanged, and that is the state after reset.

Top module: `evtIndTree`

## Requirements
- R1: After reset the interrupt request is 0, every enable reads back 0, and the pin output-enable and data equal the GPIO inputs.
- R2: The global word at byte address 0x00 holds the interrupt master enable in bit 0 and the indicator master enable in bit 1. Register reads return data on `regRdData` one clock after the address is presented, and all other bits read 0.
- R3: Counter i has a command word at address 0x10*(i+1)+0x04. Its bits are: bit 0 wrap-class enable, bit 1 trigger-class enable, bit 2 threshold-class enable, bit 3 counter interrupt enable, bit 4 counter indicator-output enable. Only these five bits are stored.
- R4: Counter i has an event word at 0x10*(i+1)+0x08. It reads the live wrap flag in bit 26, the trigger flag in bit 25 and the threshold flag in bit 24, with all other bits 0. Writes to this word change no state.
- R5: An event flag contributes to neither output unless its own class enable is set in that counter's command word.
- R6: The interrupt status sets at a clock edge where the interrupt master enable is set and at least one counter has both its interrupt enable and an enabled, asserted event flag. `irqReq` shows the status bit directly.
- R7: The status bit stays set after the events go away. It clears only when a write to address 0x04 carries a 1 in bit 0, and writing 0 there has no effect. Reading 0x04 returns the status in bit 0.
- R8: If the set condition and a clearing write fall on the same edge, the status ends up set.
- R9: The indicator is the OR, over counters with the indicator-output enable set, of their enabled asserted flags, gated by the indicator master enable. It is registered once, is not latched, and does not depend on any interrupt enable.
- R10: While the indicator master enable is set, `pinOe` is 1 and `pinDo` carries the indicator. Otherwise `pinOe`/`pinDo` equal `gpioOe`/`gpioDo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrData | input | DATA_W | Write data |
| regWrEn | input | 1 | Write strobe for the current address |
| regRdData | output | DATA_W | Read data, one cycle after the address |
| wrapFlag | input | NUM_CNT | Per-counter overflow/underflow event |
| trigFlag | input | NUM_CNT | Per-counter command-trigger event |
| thrFlag | input | NUM_CNT | Per-counter threshold event |
| gpioOe | input | 1 | GPIO output-enable for the shared pin |
| gpioDo | input | 1 | GPIO output data for the shared pin |
| pinOe | output | 1 | Output-enable driven to the shared pin |
| pinDo | output | 1 | Data driven to the shared pin |
| irqReq | output | 1 | Interrupt request, equal to the status bit |

## Verification
The set of the interrupt status by a qualified event and the software write-one-to-clear can land on the same clock edge. The bench provokes this in two ways. In the first, an event is held asserted while a clearing write is issued to an already-set status. In the second, an event is raised in the very cycle that the clearing write to a clear status is presented. Both cases are judged by `irqReq` after that edge, which must be 1. A clearing write with no concurrent event must drop it to 0.

// File: rtl/evtInd_pkg.sv
package evtInd_pkg;

  // Event word bit positions (fixed, decoded by software)
  localparam int WRAP_BIT = 26;
  localparam int TRIG_BIT = 25;
  localparam int THR_BIT  = 24;

  // Address layout
  localparam int GLB_OFS    = 'h00;
  localparam int STS_OFS    = 'h04;
  localparam int WIN_STRIDE = 'h10;
  localparam int CMD_OFS    = 'h04;
  localparam int EVT_OFS    = 'h08;

  localparam int CMD_BITS = 5;

  // Counter command word, bit 0 = wrapEn ... bit 4 = indOutEn
  typedef struct packed {
    logic indOutEn;
    logic irqEn;
    logic thrEn;
    logic trigEn;
    logic wrapEn;
  } cntCmd_t;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic irqGlobalEn;
    logic indGlobalEn;
    logic clrIrq;
  } ctrl_t;

endpackage

// File: rtl/evtIndRegs.sv
module evtIndRegs
  import evtInd_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic                        regWrEn,
  input  logic [NUM_CNT-1:0]          wrapFlag,
  input  logic [NUM_CNT-1:0]          trigFlag,
  input  logic [NUM_CNT-1:0]          thrFlag,
  input  logic                        irqStatus,
  output ctrl_t                       ctrl,
  output cntCmd_t [NUM_CNT-1:0]       cmdVec,
  output logic [DATA_W-1:0]           regRdData
);

  localparam logic [ADDR_W-1:0] GLB_A = ADDR_W'(GLB_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  function automatic logic [ADDR_W-1:0] cmdAddr(input int idx);
    return ADDR_W'(WIN_STRIDE * (idx + 1) + CMD_OFS);
  endfunction

  function automatic logic [ADDR_W-1:0] evtAddr(input int idx);
    return ADDR_W'(WIN_STRIDE * (idx + 1) + EVT_OFS);
  endfunction

  logic irqGlobalQ;
  logic indGlobalQ;
  logic [DATA_W-1:0] rdNext;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:CMD_BITS];

  // Global enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqGlobalQ <= 1'b0;
      indGlobalQ <= 1'b0;
    end else if (regWrEn && (regAddr == GLB_A)) begin
      irqGlobalQ <= regWrData[0];
      indGlobalQ <= regWrData[1];
    end
  end

  // Per-counter command words
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cmd
    localparam logic [ADDR_W-1:0] MY_CMD_A = cmdAddr(i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdVec[i] <= '0;
      end else if (regWrEn && (regAddr == MY_CMD_A)) begin
        cmdVec[i] <= cntCmd_t'(regWrData[CMD_BITS-1:0]);
      end
    end
  end

  always_comb begin
    ctrl.irqGlobalEn = irqGlobalQ;
    ctrl.indGlobalEn = indGlobalQ;
    ctrl.clrIrq      = regWrEn && (regAddr == STS_A) && regWrData[0];
  end

  // Read mux
  always_comb begin
    rdNext = '0;
    if (regAddr == GLB_A) begin
      rdNext[0] = irqGlobalQ;
      rdNext[1] = indGlobalQ;
    end
    if (regAddr == STS_A) begin
      rdNext[0] = irqStatus;
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regAddr == cmdAddr(i)) begin
        rdNext[CMD_BITS-1:0] = cmdVec[i];
      end
      if (regAddr == evtAddr(i)) begin
        rdNext[WRAP_BIT] = wrapFlag[i];
        rdNext[TRIG_BIT] = trigFlag[i];
        rdNext[THR_BIT]  = thrFlag[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= rdNext;
  end

endmodule

// File: rtl/evtIndDatapath.sv
module evtIndDatapath
  import evtInd_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_t                 ctrl,
  input  cntCmd_t [NUM_CNT-1:0] cmdVec,
  input  logic [NUM_CNT-1:0]    wrapFlag,
  input  logic [NUM_CNT-1:0]    trigFlag,
  input  logic [NUM_CNT-1:0]    thrFlag,
  input  logic                  gpioOe,
  input  logic                  gpioDo,
  output logic                  irqSet,
  output logic                  irqStatusQ,
  output logic                  pinOe,
  output logic                  pinDo
);

  logic [NUM_CNT-1:0] hitVec;
  logic [NUM_CNT-1:0] irqSrc;
  logic [NUM_CNT-1:0] indSrc;
  logic indNext;
  logic indQ;

  // Per-counter gating leaves
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_leaf
    assign hitVec[i] = (wrapFlag[i] & cmdVec[i].wrapEn)
                     | (trigFlag[i] & cmdVec[i].trigEn)
                     | (thrFlag[i]  & cmdVec[i].thrEn);
    assign irqSrc[i] = hitVec[i] & cmdVec[i].irqEn;
    assign indSrc[i] = hitVec[i] & cmdVec[i].indOutEn;
  end

  assign irqSet  = ctrl.irqGlobalEn & (|irqSrc);
  assign indNext = ctrl.indGlobalEn & (|indSrc);

  // Sticky status: set dominates clear
  always_ff @(posedge clk) begin
    if (!rstN)        irqStatusQ <= 1'b0;
    else if (irqSet)  irqStatusQ <= 1'b1;
    else if (ctrl.clrIrq) irqStatusQ <= 1'b0;
  end

  // Glitch-free indicator
  always_ff @(posedge clk) begin
    if (!rstN) indQ <= 1'b0;
    else       indQ <= indNext;
  end

  // Pin multiplexer
  always_comb begin
    if (ctrl.indGlobalEn) begin
      pinOe = 1'b1;
      pinDo = indQ;
    end else begin
      pinOe = gpioOe;
      pinDo = gpioDo;
    end
  end

endmodule

// File: rtl/evtIndTree.sv
module evtIndTree
  import evtInd_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regWrEn,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_CNT-1:0] wrapFlag,
  input  logic [NUM_CNT-1:0] trigFlag,
  input  logic [NUM_CNT-1:0] thrFlag,
  input  logic               gpioOe,
  input  logic               gpioDo,
  output logic               pinOe,
  output logic               pinDo,
  output logic               irqReq
);

  ctrl_t                 ctrl;
  cntCmd_t [NUM_CNT-1:0] cmdVec;
  logic irqStatusQ;
  logic irqSet;
  logic clrIrq;
  logic gIrqEn;
  logic gIndEn;

  evtIndRegs #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .wrapFlag(wrapFlag), .trigFlag(trigFlag), .thrFlag(thrFlag),
    .irqStatus(irqStatusQ),
    .ctrl(ctrl), .cmdVec(cmdVec), .regRdData(regRdData)
  );

  evtIndDatapath #(.NUM_CNT(NUM_CNT)) uDp (
    .clk(clk), .rstN(rstN),
    .ctrl(ctrl), .cmdVec(cmdVec),
    .wrapFlag(wrapFlag), .trigFlag(trigFlag), .thrFlag(thrFlag),
    .gpioOe(gpioOe), .gpioDo(gpioDo),
    .irqSet(irqSet), .irqStatusQ(irqStatusQ),
    .pinOe(pinOe), .pinDo(pinDo)
  );

  assign irqReq = irqStatusQ;
  assign clrIrq = ctrl.clrIrq;
  assign gIrqEn = ctrl.irqGlobalEn;
  assign gIndEn = ctrl.indGlobalEn;

endmodule

// File: rtl/evtIndTree_chk.sv
module evtIndTree_chk (
  input logic clk,
  input logic rstN,
  input logic irqReq,
  input logic irqSet,
  input logic clrIrq,
  input logic gIrqEn,
  input logic gIndEn,
  input logic gpioOe,
  input logic gpioDo,
  input logic pinOe,
  input logic pinDo
);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqSet |=> irqReq);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !clrIrq) |=> irqReq);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && clrIrq && !irqSet) |=> !irqReq);

  p_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($past(irqSet) && $past(gIrqEn)));

  p_gpio_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    !gIndEn |-> ((pinOe == gpioOe) && (pinDo == gpioDo)));

  p_ind_drive_r10: assert property (@(posedge clk) disable iff (!rstN)
    gIndEn |-> pinOe);

  p_ind_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gIndEn && !$past(gIndEn)) |-> !pinDo);

endmodule

bind evtIndTree evtIndTree_chk uChk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqSet(irqSet),
  .clrIrq(clrIrq), .gIrqEn(gIrqEn), .gIndEn(gIndEn),
  .gpioOe(gpioOe), .gpioDo(gpioDo), .pinOe(pinOe), .pinDo(pinDo)
);

// File: tb/test_evtIndTree.sv
`timescale 1ns/1ps
module test_evtIndTree;

  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic regWrEn = 1'b0;
  logic [DW-1:0] regRdData;
  logic [NC-1:0] wrapFlag = '0;
  logic [NC-1:0] trigFlag = '0;
  logic [NC-1:0] thrFlag = '0;
  logic gpioOe = 1'b1;
  logic gpioDo = 1'b1;
  logic pinOe, pinDo, irqReq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  evtIndTree #(.NUM_CNT(NC), .ADDR_W(AW), .DATA_W(DW)) i_evtIndTree (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .wrapFlag(wrapFlag),
    .trigFlag(trigFlag), .thrFlag(thrFlag), .gpioOe(gpioOe), .gpioDo(gpioDo),
    .pinOe(pinOe), .pinDo(pinDo), .irqReq(irqReq)
  );

  function automatic logic [AW-1:0] cmdA(input int i);
    return AW'(16 * (i + 1) + 4);
  endfunction
  function automatic logic [AW-1:0] evtA(input int i);
    return AW'(16 * (i + 1) + 8);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    regAddr = a; regWrEn = 1'b0;
    tick();
    check(tag, regRdData, exp);
  endtask

  task automatic clearAll();
    wrapFlag = '0; trigFlag = '0; thrFlag = '0;
    writeReg(8'h00, 0);
    for (int i = 0; i < NC; i++) writeReg(cmdA(i), 0);
    writeReg(8'h04, 1);
  endtask

  // R1
  task automatic testReset();
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 pinOe", 32'(pinOe), 1);
    check("R1 pinDo", 32'(pinDo), 1);
    readCheck(8'h00, 0, "R1 global");
    readCheck(cmdA(0), 0, "R1 cmd0");
    readCheck(cmdA(NC-1), 0, "R1 cmdLast");
  endtask

  // R2, R3
  task automatic testRegs();
    writeReg(8'h00, 32'h3);
    readCheck(8'h00, 32'h3, "R2 global readback");
    writeReg(8'h00, 32'hFFFF_FFFD);
    readCheck(8'h00, 32'h1, "R2 global masked");
    writeReg(cmdA(2), 32'h1F);
    readCheck(cmdA(2), 32'h1F, "R3 cmd2 all");
    writeReg(cmdA(1), 32'hFFFF_FFEA);
    readCheck(cmdA(1), 32'h0A, "R3 cmd1 masked");
    readCheck(cmdA(0), 0, "R3 cmd0 untouched");
    clearAll();
  endtask

  // R4
  task automatic testEvtWord();
    wrapFlag[1] = 1'b1; thrFlag[1] = 1'b1;
    readCheck(evtA(1), (32'h1 << 26) | (32'h1 << 24), "R4 evt1 wrap+thr");
    wrapFlag[1] = 1'b0; thrFlag[1] = 1'b0; trigFlag[1] = 1'b1;
    readCheck(evtA(1), 32'h1 << 25, "R4 evt1 trig");
    writeReg(evtA(1), 32'hFFFF_FFFF);
    readCheck(evtA(1), 32'h1 << 25, "R4 evt write ignored");
    readCheck(cmdA(1), 0, "R4 cmd1 unchanged by evt write");
    readCheck(8'h00, 0, "R4 global unchanged by evt write");
    clearAll();
  endtask

  // R5, R6, R9
  task automatic testClassGate();
    writeReg(8'h00, 32'h3);
    writeReg(cmdA(0), 32'h1A); // trig + irq + indOut
    wrapFlag[0] = 1'b1; thrFlag[0] = 1'b1;
    tick(); tick();
    check("R5 disabled classes irq", 32'(irqReq), 0);
    check("R5 disabled classes pin", 32'(pinDo), 0);
    trigFlag[0] = 1'b1;
    tick();
    check("R6 enabled class irq", 32'(irqReq), 1);
    check("R9 enabled class pin", 32'(pinDo), 1);
    wrapFlag = '0; trigFlag = '0; thrFlag = '0;
    tick();
    check("R9 not latched", 32'(pinDo), 0);
    check("R7 stays set", 32'(irqReq), 1);
    clearAll();
  endtask

  // R6, R9
  task automatic testIrqQualify();
    writeReg(8'h00, 32'h2);        // indicator only
    writeReg(cmdA(0), 32'h1F);
    wrapFlag[0] = 1'b1;
    tick();
    check("R6 no global irq en", 32'(irqReq), 0);
    check("R9 independent of irq", 32'(pinDo), 1);
    wrapFlag[0] = 1'b0;
    writeReg(cmdA(0), 32'h17);     // no counter irq en
    writeReg(8'h00, 32'h3);
    wrapFlag[0] = 1'b1;
    tick();
    check("R6 no counter irq en", 32'(irqReq), 0);
    check("R9 pin with irq off", 32'(pinDo), 1);
    clearAll();
  endtask

  // R7, R8
  task automatic testLatch();
    writeReg(8'h00, 32'h1);
    writeReg(cmdA(0), 32'h09);
    wrapFlag[0] = 1'b1;
    tick();
    wrapFlag[0] = 1'b0;
    tick(); tick();
    check("R7 held after event", 32'(irqReq), 1);
    writeReg(8'h04, 32'h0);
    check("R7 write zero no effect", 32'(irqReq), 1);
    readCheck(8'h04, 1, "R7 status read");
    writeReg(8'h04, 32'h1);
    check("R7 w1c clears", 32'(irqReq), 0);
    readCheck(8'h04, 0, "R7 status read cleared");
    wrapFlag[0] = 1'b1;
    tick();
    writeReg(8'h04, 32'h1);
    check("R8 held event beats clear", 32'(irqReq), 1);
    wrapFlag[0] = 1'b0;
    writeReg(8'h04, 32'h1);
    check("R8 clear without event", 32'(irqReq), 0);
    wrapFlag[0] = 1'b1;
    writeReg(8'h04, 32'h1);
    check("R8 same-edge set and clear", 32'(irqReq), 1);
    clearAll();
  endtask

  // R10, R9
  task automatic testPinMux();
    gpioOe = 1'b1; gpioDo = 1'b0; #1;
    check("R10 gpio oe1 do0 oe", 32'(pinOe), 1);
    check("R10 gpio oe1 do0 do", 32'(pinDo), 0);
    gpioOe = 1'b0; gpioDo = 1'b1; #1;
    check("R10 gpio oe0 do1 oe", 32'(pinOe), 0);
    check("R10 gpio oe0 do1 do", 32'(pinDo), 1);
    writeReg(8'h00, 32'h2);
    check("R10 override oe", 32'(pinOe), 1);
    check("R10 override do", 32'(pinDo), 0);
    writeReg(cmdA(3), 32'h04);     // thr enabled, no indOut
    thrFlag[3] = 1'b1;
    tick();
    check("R9 needs indOut en", 32'(pinDo), 0);
    writeReg(cmdA(3), 32'h14);
    tick();
    check("R9 counter3 thr drives pin", 32'(pinDo), 1);
    writeReg(8'h00, 32'h0);
    check("R10 released oe", 32'(pinOe), 0);
    check("R10 released do", 32'(pinDo), 1);
    clearAll();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    testReset();
    testRegs();
    testEvtWord();
    testClassGate();
    testIrqQualify();
    testLatch();
    testPinMux();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule